// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags and Multiprocessor Wake-Up

This block turns a single asynchronous non-return-to-zero input line into parallel characters. It looks for a falling edge to find the start of a frame. It samples the line eight times per bit and settles each bit by a three-sample majority vote near the middle of the bit. The assembled character goes into a receive buffer register. The frame format is set by the inputs: one to eight data bits sent least-significant first, an optional even or odd parity bit, and one or two stop bits. An optional address bit can also be enabled. The sample rate comes from a 16-bit divisor input that the matching transmitter also uses.

Four error conditions are flagged separately:
- parity mismatch
- overrun of an unread character
- a low stop bit (framing error)
- a line held low for longer than a whole frame (break)

A combined error flag is the OR of the four. Two interrupt requests are derived from the flags. A read strobe from the CPU acknowledges the buffer.

Two multiprocessor wake-up schemes mark each frame as an address or as data:
- Idle-line mode: the first frame after a long idle gap is an address.
- Address-bit mode: an extra bit after the data bits carries the mark.

While the sleep input is high in either mode, only address frames reach the buffer.

Top module: `serial_rx_unit`

## Requirements
- R1: After a synchronous reset, the following outputs are all 0: rx_ready, rx_data, addr_flag, all error flags, err_any, irq_rx and irq_err.
- R2: Sample timing, start detection and character delivery:
  - One sample is taken every baud_div+1 clocks, and one bit lasts 8 samples.
  - A high-to-low change of the line while idle begins a frame, and the start bit is confirmed by majority vote.
  - The data_len+1 data bits arrive least-significant first and are delivered right-aligned in rx_data.
  - rx_ready rises once per delivered frame, near the end of its last stop bit.
- R3: par_mode selects the parity: 2'b01 is even, 2'b10 is odd, and 2'b00 or 2'b11 is none. When parity is on, its bit follows the data bits (and the address bit, if one is present). err_parity shows whether the last delivered character had a wrong parity bit.
- R4: err_overrun is set when a character is delivered while rx_ready is still high. The newer character replaces the older one in rx_data.
- R5: err_frame shows that a stop bit of the last delivered character was sampled low. When two_stop is 1, both stop bits are checked.
- R6: err_break is set when the line stays low for one bit period longer than a full frame. Start, data, address, parity and stop bits all count toward the frame. A break cannot be detected again until the line has returned high.
- R7: err_any is the OR of err_parity, err_overrun, err_frame and err_break.
- R8: A pulse on rd_stb clears rx_ready, err_overrun and err_break. It does not clear err_parity or err_frame.
- R9: The interrupt outputs are formed as follows:
  - irq_rx is rx_ready gated by rx_int_en.
  - irq_err is the parity, overrun or framing flag gated by err_int_en.
  - err_break drives irq_err whatever the value of err_int_en.
- R10: While rx_en is 0, line activity delivers no characters and raises no flags.
- R11: In idle-line wake-up (wake_mode 2'b01), the first frame that starts after at least 10 high bit periods is an address frame. addr_flag reports this for the delivered character.
- R12: In address-bit wake-up (wake_mode 2'b10), one extra bit follows the data bits. A value of 1 marks an address frame and 0 marks a data frame, and addr_flag reports this bit.
- R13: With sleep at 1 and wake_mode 2'b01 or 2'b10, frames that are not address frames leave rx_data, rx_ready and the flags unchanged. With sleep at 0, every frame is delivered.
- R14: A low pulse shorter than three eighths of a bit fails the start-bit vote and delivers nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| baud_div | input | 16 | Sample period minus one, in clocks |
| data_len | input | 3 | Number of data bits minus one |
| par_mode | input | 2 | Parity: 01 even, 10 odd, others none |
| two_stop | input | 1 | Two stop bits when 1 |
| wake_mode | input | 2 | 00 none, 01 idle-line, 10 address-bit |
| sleep | input | 1 | Deliver only address frames when wake-up is active |
| rx_int_en | input | 1 | Enables irq_rx |
| err_int_en | input | 1 | Enables parity, overrun and framing on irq_err |
| rxd | input | 1 | Serial input line, asynchronous |
| rd_stb | input | 1 | Buffer read acknowledge |
| rx_data | output | 8 | Received character, right-aligned |
| rx_ready | output | 1 | Character waiting in the buffer |
| addr_flag | output | 1 | Buffered character was an address frame |
| err_parity | output | 1 | Parity error on the buffered character |
| err_overrun | output | 1 | Character lost through overrun |
| err_frame | output | 1 | Stop bit sampled low |
| err_break | output | 1 | Break condition seen |
| err_any | output | 1 | OR of the four error flags |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The bit-level state machine and the sample counter are hidden, and a fault in either shows up at the ports only at the end of a frame. A misplaced state transition shifts data bits or swallows the parity or address bit, so rx_data or err_parity is wrong on the very next delivered character. A wrong idle or low-run count shows up as a missing or extra addr_flag, or a missing or early err_break, within one frame time of the stimulus. A wrong wake-up decision shows up as an extra or missing rise of rx_ready at the end of the frame concerned. The scoreboard therefore compares every delivered character and counts the deliveries made after each frame that should have been dropped.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_W    = 8;
    localparam int LEN_W     = $clog2(DATA_W);
    localparam int OVS       = 8;
    localparam int IDLE_BITS = 10;
    localparam int RUN_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_ADDR,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef enum logic [1:0] {
        PM_NONE = 2'b00,
        PM_EVEN = 2'b01,
        PM_ODD  = 2'b10,
        PM_OFF  = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'b00,
        WK_IDLE = 2'b01,
        WK_ADDR = 2'b10,
        WK_OFF  = 2'b11
    } wake_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              addr;
    } rx_frame_t;

    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

    function automatic logic par_used(input logic [1:0] m);
        return (m == PM_EVEN) || (m == PM_ODD);
    endfunction

    function automatic logic par_expect(input logic [DATA_W-1:0] d, input logic [1:0] m);
        return (m == PM_ODD) ? ~(^d) : (^d);
    endfunction

    function automatic logic wake_on(input logic [1:0] w);
        return (w == WK_IDLE) || (w == WK_ADDR);
    endfunction

    function automatic logic [DATA_W-1:0] align_data(input logic [DATA_W-1:0] sh,
                                                     input logic [LEN_W-1:0]  len);
        return sh >> (DATA_W - 1 - int'(len));
    endfunction

    function automatic logic [RUN_W-1:0] break_limit(input logic [LEN_W-1:0] len,
                                                     input logic [1:0]       pm,
                                                     input logic [1:0]       wm,
                                                     input logic             two);
        int n;
        n = 1 + int'(len) + 1 + (par_used(pm) ? 1 : 0) + ((wm == WK_ADDR) ? 1 : 0)
            + (two ? 2 : 1);
        return RUN_W'((n + 1) * OVS);
    endfunction

endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             line,
    input  logic [LEN_W-1:0] len,
    input  logic [1:0]       par_mode,
    input  logic [1:0]       wake_mode,
    input  logic             two_stop,
    output logic             done,
    output rx_frame_t        frm,
    output logic             brk
);
    localparam logic [RUN_W-1:0] IDLE_LIM = RUN_W'(IDLE_BITS * OVS);

    rx_state_e         state;
    logic [2:0]        smp;
    logic [2:0]        votes;
    logic [LEN_W-1:0]  bidx;
    logic [DATA_W-1:0] sh;
    logic              pbit;
    logic              abit;
    logic              ferr;
    logic              prev;
    logic              from_idle;
    logic              idle_seen;
    logic              armed;
    logic [RUN_W-1:0]  low_run;
    logic [RUN_W-1:0]  idle_run;

    logic              bitv;
    logic [RUN_W-1:0]  brk_lim;
    logic [DATA_W-1:0] fin_data;
    logic              fin_perr;
    logic              fin_addr;

    always_comb begin
        bitv     = maj3(votes);
        brk_lim  = break_limit(len, par_mode, wake_mode, two_stop);
        fin_data = align_data(sh, len);
        fin_perr = par_used(par_mode) && (pbit != par_expect(fin_data, par_mode));
        case (wake_mode)
            WK_ADDR: fin_addr = abit;
            WK_IDLE: fin_addr = from_idle;
            default: fin_addr = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state     <= ST_IDLE;
            smp       <= '0;
            votes     <= '0;
            bidx      <= '0;
            sh        <= '0;
            pbit      <= 1'b0;
            abit      <= 1'b0;
            ferr      <= 1'b0;
            prev      <= 1'b1;
            from_idle <= 1'b0;
            idle_seen <= 1'b0;
            armed     <= 1'b1;
            low_run   <= '0;
            idle_run  <= '0;
            done      <= 1'b0;
            brk       <= 1'b0;
            frm       <= '0;
        end else begin
            done <= 1'b0;
            brk  <= 1'b0;
            if (tick) begin
                prev <= line;

                // low-run watch for break
                if (line) begin
                    low_run <= '0;
                    armed   <= 1'b1;
                end else begin
                    if (low_run != {RUN_W{1'b1}}) low_run <= low_run + 1'b1;
                    if (armed && (low_run == brk_lim)) begin
                        brk   <= 1'b1;
                        armed <= 1'b0;
                    end
                end

                // mid-bit votes
                if (state != ST_IDLE) begin
                    case (smp)
                        3'd3:    votes[0] <= line;
                        3'd4:    votes[1] <= line;
                        3'd5:    votes[2] <= line;
                        default: ;
                    endcase
                end

                if (state == ST_IDLE) begin
                    if (line) begin
                        if (idle_run == IDLE_LIM) idle_seen <= 1'b1;
                        else                      idle_run  <= idle_run + 1'b1;
                    end else begin
                        idle_run <= '0;
                        if (prev) begin
                            state     <= ST_START;
                            smp       <= 3'd1;
                            from_idle <= idle_seen;
                            idle_seen <= 1'b0;
                        end
                    end
                end else begin
                    smp <= smp + 1'b1;
                    if (smp == 3'd7) begin
                        case (state)
                            ST_START: begin
                                if (bitv) begin
                                    state <= ST_IDLE;
                                end else begin
                                    state <= ST_DATA;
                                    bidx  <= '0;
                                    sh    <= '0;
                                    ferr  <= 1'b0;
                                end
                            end
                            ST_DATA: begin
                                sh <= {bitv, sh[DATA_W-1:1]};
                                if (bidx == len) begin
                                    if (wake_mode == WK_ADDR)    state <= ST_ADDR;
                                    else if (par_used(par_mode)) state <= ST_PAR;
                                    else                         state <= ST_STOP1;
                                end else begin
                                    bidx <= bidx + 1'b1;
                                end
                            end
                            ST_ADDR: begin
                                abit  <= bitv;
                                state <= par_used(par_mode) ? ST_PAR : ST_STOP1;
                            end
                            ST_PAR: begin
                                pbit  <= bitv;
                                state <= ST_STOP1;
                            end
                            ST_STOP1: begin
                                if (two_stop) begin
                                    ferr  <= ~bitv;
                                    state <= ST_STOP2;
                                end else begin
                                    state <= ST_IDLE;
                                    done  <= 1'b1;
                                    frm   <= '{data: fin_data, perr: fin_perr,
                                               ferr: ~bitv, addr: fin_addr};
                                end
                            end
                            ST_STOP2: begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                                frm   <= '{data: fin_data, perr: fin_perr,
                                           ferr: ferr | ~bitv, addr: fin_addr};
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/srx_buffer.sv
module srx_buffer
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_frame_t         frm,
    input  logic              brk,
    input  logic              rd_stb,
    input  logic [1:0]        wake_mode,
    input  logic              sleep,
    input  logic              rx_int_en,
    input  logic              err_int_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              addr_flag,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_frame,
    output logic              err_break,
    output logic              err_any,
    output logic              irq_rx,
    output logic              irq_err
);
    logic deliver;

    always_comb begin
        deliver = !(wake_on(wake_mode) && sleep) || frm.addr;
        err_any = err_parity | err_overrun | err_frame | err_break;
        irq_rx  = rx_int_en & rx_ready;
        irq_err = (err_int_en & (err_parity | err_overrun | err_frame)) | err_break;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data     <= '0;
            rx_ready    <= 1'b0;
            addr_flag   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
            err_frame   <= 1'b0;
            err_break   <= 1'b0;
        end else begin
            if (rd_stb) begin
                rx_ready    <= 1'b0;
                err_overrun <= 1'b0;
                err_break   <= 1'b0;
            end
            if (done && deliver) begin
                rx_ready    <= 1'b1;
                err_overrun <= !rd_stb && (err_overrun || rx_ready);
                rx_data     <= frm.data;
                err_parity  <= frm.perr;
                err_frame   <= frm.ferr;
                addr_flag   <= frm.addr;
            end
            if (brk) err_break <= 1'b1;
        end
    end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import srx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [LEN_W-1:0]  data_len,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    input  logic [1:0]        wake_mode,
    input  logic              sleep,
    input  logic              rx_int_en,
    input  logic              err_int_en,
    input  logic              rxd,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              addr_flag,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_frame,
    output logic              err_break,
    output logic              err_any,
    output logic              irq_rx,
    output logic              irq_err
);
    logic      line_q1;
    logic      line_s;
    logic      tick;
    logic      frm_done;
    logic      brk_pulse;
    rx_frame_t frm;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q1 <= 1'b1;
            line_s  <= 1'b1;
        end else begin
            line_q1 <= rxd;
            line_s  <= line_q1;
        end
    end

    srx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .en   (rx_en),
        .div  (baud_div),
        .tick (tick)
    );

    srx_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .en        (rx_en),
        .tick      (tick),
        .line      (line_s),
        .len       (data_len),
        .par_mode  (par_mode),
        .wake_mode (wake_mode),
        .two_stop  (two_stop),
        .done      (frm_done),
        .frm       (frm),
        .brk       (brk_pulse)
    );

    srx_buffer u_buf (
        .clk         (clk),
        .rst         (rst),
        .done        (frm_done),
        .frm         (frm),
        .brk         (brk_pulse),
        .rd_stb      (rd_stb),
        .wake_mode   (wake_mode),
        .sleep       (sleep),
        .rx_int_en   (rx_int_en),
        .err_int_en  (err_int_en),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .addr_flag   (addr_flag),
        .err_parity  (err_parity),
        .err_overrun (err_overrun),
        .err_frame   (err_frame),
        .err_break   (err_break),
        .err_any     (err_any),
        .irq_rx      (irq_rx),
        .irq_err     (irq_err)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_en,
    input logic       rd_stb,
    input logic       rx_ready,
    input logic       err_overrun,
    input logic       err_break,
    input logic       line_s,
    input logic       frm_done,
    input logic       frm_addr,
    input logic       sleep,
    input logic [1:0] wake_mode,
    input logic [7:0] rx_data
);
    AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !frm_done) |=> !rx_ready);                                     // R8
    AST_OVERRUN_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> $past(rx_ready));                                  // R4
    AST_BREAK_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(err_break) |-> !$past(line_s));                                     // R6
    AST_READY_FROM_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> $past(frm_done));                                     // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frm_done |=> !frm_done);                                                  // R2
    AST_SLEEP_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
        (frm_done && sleep && (wake_mode == 2'b01 || wake_mode == 2'b10) && !frm_addr)
        |=> $stable(rx_data));                                                    // R13
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !frm_done);                                                    // R10
endmodule

bind serial_rx_unit srx_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_en       (rx_en),
    .rd_stb      (rd_stb),
    .rx_ready    (rx_ready),
    .err_overrun (err_overrun),
    .err_break   (err_break),
    .line_s      (line_s),
    .frm_done    (frm_done),
    .frm_addr    (frm.addr),
    .sleep       (sleep),
    .wake_mode   (wake_mode),
    .rx_data     (rx_data)
);

// File: tb/tb_serial_rx_unit.sv
module tb_serial_rx_unit;
    localparam int DIVV = 3;
    localparam int BIT  = 8 * (DIVV + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b1;
    logic [15:0] baud_div = 16'(DIVV);
    logic [2:0]  data_len = 3'd7;
    logic [1:0]  par_mode = 2'b00;
    logic        two_stop = 1'b0;
    logic [1:0]  wake_mode = 2'b00;
    logic        sleep = 1'b0;
    logic        rx_int_en = 1'b0;
    logic        err_int_en = 1'b0;
    logic        rxd = 1'b1;
    logic        rd_mon = 1'b0;
    logic        rd_main = 1'b0;
    logic        rd_stb;
    logic [7:0]  rx_data;
    logic        rx_ready, addr_flag, err_parity, err_overrun, err_frame;
    logic        err_break, err_any, irq_rx, irq_err;

    assign rd_stb = rd_mon | rd_main;

    always #10 clk = ~clk;

    serial_rx_unit dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .baud_div(baud_div), .data_len(data_len),
        .par_mode(par_mode), .two_stop(two_stop), .wake_mode(wake_mode), .sleep(sleep),
        .rx_int_en(rx_int_en), .err_int_en(err_int_en), .rxd(rxd), .rd_stb(rd_stb),
        .rx_data(rx_data), .rx_ready(rx_ready), .addr_flag(addr_flag),
        .err_parity(err_parity), .err_overrun(err_overrun), .err_frame(err_frame),
        .err_break(err_break), .err_any(err_any), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    typedef struct {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       addr;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   rx_seen = 0;
    bit   auto_read = 1'b1;
    bit   done_flag = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bits(input logic v, input int n);
        rxd = v;
        repeat (n * BIT) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input logic bad_par,
                        input logic abit, input logic stop_ok, input logic deliver,
                        input logic exp_addr, input string req);
        logic [7:0] dm;
        logic       p;
        logic       pon;
        exp_t       e;
        dm  = d & (8'hFF >> (8 - nb));
        pon = (par_mode == 2'b01) || (par_mode == 2'b10);
        p   = (par_mode == 2'b10) ? ~(^dm) : (^dm);
        if (deliver) begin
            e.data = dm;
            e.perr = bad_par && pon;
            e.ferr = !stop_ok;
            e.addr = exp_addr;
            e.req  = req;
            q.push_back(e);
        end
        hold_bits(1'b0, 1);
        for (int i = 0; i < nb; i++) hold_bits(dm[i], 1);
        if (wake_mode == 2'b10) hold_bits(abit, 1);
        if (pon) hold_bits(p ^ bad_par, 1);
        hold_bits(stop_ok, 1);
        if (two_stop) hold_bits(1'b1, 1);
        hold_bits(1'b1, 2);
    endtask

    task automatic read_pulse();
        rd_main = 1'b1;
        @(negedge clk);
        rd_main = 1'b0;
        @(negedge clk);
    endtask

    task automatic push_break_item(input string req);
        exp_t e;
        e.data = 8'h00;
        e.perr = 1'b0;
        e.ferr = 1'b1;
        e.addr = 1'b0;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // monitor: scoreboard compare on each new character
    initial begin
        logic prev_rdy;
        exp_t e;
        prev_rdy = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && rx_ready && !prev_rdy) begin
                rx_seen++;
                if (q.size() == 0) begin
                    chk(1'b0, "R2 unexpected delivery", 32'(rx_data), 32'h0);
                end else begin
                    e = q.pop_front();
                    chk(rx_data == e.data, {e.req, " data"}, 32'(rx_data), 32'(e.data));
                    chk(err_parity == e.perr, {"R3 parity flag ", e.req},
                        32'(err_parity), 32'(e.perr));
                    chk(err_frame == e.ferr, {"R5 frame flag ", e.req},
                        32'(err_frame), 32'(e.ferr));
                    chk(addr_flag == e.addr, {"R11 R12 addr_flag ", e.req},
                        32'(addr_flag), 32'(e.addr));
                end
                if (auto_read) begin
                    rd_mon = 1'b1;
                    @(negedge clk);
                    rd_mon = 1'b0;
                end
            end
            prev_rdy = rx_ready;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int seen0;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rx_ready == 1'b0, "R1 rx_ready", 32'(rx_ready), 32'h0);
        chk(rx_data == 8'h00, "R1 rx_data", 32'(rx_data), 32'h0);
        chk(err_any == 1'b0 && err_break == 1'b0 && addr_flag == 1'b0,
            "R1 flags", 32'({err_any, err_break, addr_flag}), 32'h0);
        chk(irq_rx == 1'b0 && irq_err == 1'b0, "R1 irqs", 32'({irq_rx, irq_err}), 32'h0);
        hold_bits(1'b1, 12);

        // R2 eight-bit characters
        send(8'hA5, 8, 0, 0, 1, 1, 0, "R2 8N1 A5");
        send(8'h3C, 8, 0, 0, 1, 1, 0, "R2 8N1 3C");
        chk(rx_seen == 2, "R2 delivery count", 32'(rx_seen), 32'd2);
        // R2 shorter lengths
        data_len = 3'd4;
        send(8'h16, 5, 0, 0, 1, 1, 0, "R2 5-bit");
        data_len = 3'd0;
        send(8'h01, 1, 0, 0, 1, 1, 0, "R2 1-bit");
        data_len = 3'd7;

        // R3 parity even then odd
        par_mode = 2'b01;
        send(8'h37, 8, 0, 0, 1, 1, 0, "R3 even ok");
        send(8'h37, 8, 1, 0, 1, 1, 0, "R3 even bad");
        chk(err_any == 1'b1, "R7 err_any on parity", 32'(err_any), 32'h1);
        err_int_en = 1'b1;
        @(negedge clk);
        chk(irq_err == 1'b1, "R9 irq_err parity enabled", 32'(irq_err), 32'h1);
        err_int_en = 1'b0;
        @(negedge clk);
        chk(irq_err == 1'b0, "R9 irq_err parity masked", 32'(irq_err), 32'h0);
        par_mode = 2'b10;
        send(8'h0F, 8, 0, 0, 1, 1, 0, "R3 odd ok");
        send(8'h0F, 8, 1, 0, 1, 1, 0, "R3 odd bad");

        // two stop bits
        par_mode = 2'b00;
        two_stop = 1'b1;
        send(8'h81, 8, 0, 0, 1, 1, 0, "R5 two stop");
        two_stop = 1'b0;

        // R5 framing
        send(8'h55, 8, 0, 0, 0, 1, 0, "R5 low stop");
        chk(err_frame == 1'b1, "R5 err_frame held", 32'(err_frame), 32'h1);

        // R4 overrun, R8 read, R9 irq_rx
        auto_read = 1'b0;
        rx_int_en = 1'b1;
        send(8'h11, 8, 0, 0, 1, 1, 0, "R4 first");
        send(8'h22, 8, 0, 0, 1, 0, 0, "R4 second");
        chk(err_overrun == 1'b1, "R4 overrun set", 32'(err_overrun), 32'h1);
        chk(rx_data == 8'h22, "R4 newer data kept", 32'(rx_data), 32'h22);
        chk(err_any == 1'b1, "R7 err_any on overrun", 32'(err_any), 32'h1);
        chk(irq_rx == 1'b1, "R9 irq_rx", 32'(irq_rx), 32'h1);
        read_pulse();
        chk(rx_ready == 1'b0 && err_overrun == 1'b0, "R8 read clears",
            32'({rx_ready, err_overrun}), 32'h0);
        chk(irq_rx == 1'b0, "R9 irq_rx after read", 32'(irq_rx), 32'h0);
        rx_int_en = 1'b0;
        auto_read = 1'b1;

        // R14 start glitch
        seen0 = rx_seen;
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        hold_bits(1'b1, 3);
        chk(rx_seen == seen0, "R14 glitch ignored", 32'(rx_seen), 32'(seen0));

        // R10 disabled receiver
        rx_en = 1'b0;
        send(8'h99, 8, 0, 0, 1, 0, 0, "R10 disabled");
        chk(rx_seen == seen0 && rx_ready == 1'b0, "R10 nothing delivered",
            32'(rx_seen), 32'(seen0));
        rx_en = 1'b1;
        hold_bits(1'b1, 2);

        // R12 R13 address-bit wake-up
        wake_mode = 2'b10;
        sleep = 1'b1;
        seen0 = rx_seen;
        send(8'h44, 8, 0, 0, 1, 0, 0, "R13 data dropped");
        chk(rx_seen == seen0, "R13 addr-bit data frame dropped", 32'(rx_seen), 32'(seen0));
        send(8'h09, 8, 0, 1, 1, 1, 1, "R12 address frame");
        sleep = 1'b0;
        send(8'h66, 8, 0, 0, 1, 1, 0, "R12 data after wake");
        chk(rx_seen == seen0 + 2, "R13 addr-bit deliveries", 32'(rx_seen), 32'(seen0 + 2));

        // R11 R13 idle-line wake-up
        wake_mode = 2'b01;
        sleep = 1'b1;
        hold_bits(1'b1, 12);
        seen0 = rx_seen;
        send(8'h5A, 8, 0, 0, 1, 1, 1, "R11 first after idle");
        send(8'h77, 8, 0, 0, 1, 0, 0, "R13 idle data dropped");
        chk(rx_seen == seen0 + 1, "R13 idle data frame dropped", 32'(rx_seen), 32'(seen0 + 1));
        sleep = 1'b0;
        send(8'h78, 8, 0, 0, 1, 1, 0, "R11 data in block");
        wake_mode = 2'b00;

        // R6 break
        push_break_item("R6 break frame");
        hold_bits(1'b0, 20);
        chk(err_break == 1'b1, "R6 break set", 32'(err_break), 32'h1);
        chk(irq_err == 1'b1, "R9 break irq unmasked", 32'(irq_err), 32'h1);
        chk(err_any == 1'b1, "R7 err_any on break", 32'(err_any), 32'h1);
        read_pulse();
        chk(err_break == 1'b0, "R8 read clears break", 32'(err_break), 32'h0);
        hold_bits(1'b0, 15);
        chk(err_break == 1'b0, "R6 no re-detect while low", 32'(err_break), 32'h0);
        hold_bits(1'b1, 3);
        push_break_item("R6 second break frame");
        hold_bits(1'b0, 20);
        chk(err_break == 1'b1, "R6 break after high", 32'(err_break), 32'h1);
        hold_bits(1'b1, 3);
        read_pulse();

        chk(q.size() == 0, "R2 all expected characters seen", 32'(q.size()), 32'h0);
        done_flag = 1'b1;
        finish_run();
    end
endmodule